// File: doc/BRIEF.md
# CAN Transmit Request Controller

This block keeps the software-visible state of one outgoing frame for a small CAN controller. A CPU arms a transmission by writing 1 to a start bit, and asks for withdrawal by writing 0 to it. A protocol engine reports what happens on the wire through single-cycle strobes: arbitration won, arbitration lost, transmit error and frame completed. It also drives a level that is high while the node is bus-off. From these inputs the block keeps the start and pending flags, a sticky transmit-error flag and a retransmit request. Withdrawal only succeeds in bus phases where no frame of this node is on the wire.

The block also keeps the empty flag for a two-byte data staging pair. The flag tells software when the second staging register has been consumed and may be refilled.

After a transmit error, frames with few data bytes are retried without software help. Longer frames wait until software has reloaded the data and writes the start bit again. Every flag is a register that drives its output port directly, so each flag can be read in the cycle it changes.

Top module: `can_tx_request`

## Requirements
- R1: After reset, startFlag, txPending, txErrFlag and retxReq are 0 and bufEmpty is 1.
- R2: A control write with cpuStartBit=1 while busOff is low sets startFlag and txPending at the next clock edge. The two flags stay 1 until completion, a successful withdrawal or bus-off.
- R3: A control write with cpuStartBit=0 before arbitration is won clears both flags at that edge. After arbitration is won, the same write leaves both flags at 1 until evFrameDone, and evFrameDone then clears them.
- R4: evArbLost during a transmission clears both flags if a withdrawal is outstanding. With no outstanding withdrawal, the flags stay 1 and the request waits for the bus again.
- R5: While busOff is high, both flags are cleared at each edge, and a control write with cpuStartBit=1 is ignored.
- R6: evFrameDone during a transmission clears both flags and sets bufEmpty. If a control write with cpuStartBit=1 falls in the same cycle, both flags read 1 after that edge and the request is armed again.
- R7: evTxErr during a transmission with dataLen of 2 or less gives a one-cycle retxReq pulse and keeps both flags set. If a withdrawal is outstanding, the error clears both flags instead and gives no pulse.
- R8: evTxErr during a transmission with dataLen above 2 gives no retxReq and keeps both flags set. A later control write with cpuStartBit=1 gives a one-cycle retxReq pulse. A later write with cpuStartBit=0 clears both flags.
- R9: bufEmpty clears on every cpuWrData2 and sets on evShiftLoad2. When both come in the same cycle, the write wins and bufEmpty becomes 0.
- R10: evTxErr during a transmission sets txErrFlag. Only a control write with cpuErrBit=0 clears it, and a control write with cpuErrBit=1 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuWrCtl | input | 1 | CPU write strobe for the control bits |
| cpuStartBit | input | 1 | Start bit value carried by the control write |
| cpuErrBit | input | 1 | Error flag value carried by the control write (0 clears) |
| cpuWrData2 | input | 1 | CPU write strobe for the second staging register |
| dataLen | input | 4 | Number of data bytes in the frame (0 to 8) |
| evTxStart | input | 1 | Engine strobe: arbitration won, frame on the wire |
| evArbLost | input | 1 | Engine strobe: arbitration lost |
| evTxErr | input | 1 | Engine strobe: error during transmission |
| evFrameDone | input | 1 | Engine strobe: frame sent successfully |
| evShiftLoad2 | input | 1 | Engine strobe: second staging register copied to the shifter |
| busOff | input | 1 | High while the node is bus-off |
| startFlag | output | 1 | Start bit as software reads it |
| txPending | output | 1 | Transmission pending |
| bufEmpty | output | 1 | Second staging register may be refilled |
| txErrFlag | output | 1 | Sticky transmit error flag |
| retxReq | output | 1 | One-cycle request to the engine to transmit again |

## Verification
Every result of this block is due exactly one rising edge after the inputs that cause it. This holds for flag sets and clears, withdrawals, re-arming on completion and the retransmit pulse. Inputs change on the falling edge. The outputs are then compared at the next falling edge against a behavioural model that updates on the rising edge in between. Because retxReq is a one-cycle pulse, it is checked in that one window and again one cycle later, where it must already be low.

// File: rtl/can_tx_request_pkg.sv
package can_tx_request_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_WAIT,
    PH_ACTIVE,
    PH_ERRHOLD
  } txPhase_t;

  typedef struct packed {
    logic setArm;
    logic clrArm;
    logic setBufEmpty;
    logic setErr;
  } txStrobe_t;

endpackage

// File: rtl/can_tx_request_ctl.sv
module can_tx_request_ctl
  import can_tx_request_pkg::*;
#(
  parameter int MAX_DATA_BYTES = 8,
  parameter int AUTO_RETX_MAX  = 2,
  localparam int LEN_W = $clog2(MAX_DATA_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cpuWrCtl,
  input  logic             cpuStartBit,
  input  logic [LEN_W-1:0] dataLen,
  input  logic             evTxStart,
  input  logic             evArbLost,
  input  logic             evTxErr,
  input  logic             evFrameDone,
  input  logic             busOff,
  output txStrobe_t        strobe,
  output logic             retxReq
);

  localparam logic [LEN_W-1:0] RETX_LIM = LEN_W'(AUTO_RETX_MAX);

  txPhase_t phaseQ, phaseD;
  logic     cancelQ, cancelD;
  logic     retxQ, retxD;
  logic     armReq, cancelAfter, shortFrame;

  // A start write while bus-off is dropped; a start write also withdraws
  // any earlier cancel request.
  assign armReq      = cpuWrCtl & cpuStartBit & ~busOff;
  assign cancelAfter = ~armReq & (cancelQ | (cpuWrCtl & ~cpuStartBit));
  assign shortFrame  = (dataLen <= RETX_LIM);

  always_comb begin
    phaseD  = phaseQ;
    cancelD = 1'b0;
    retxD   = 1'b0;
    strobe  = '0;
    if (busOff) begin
      strobe.clrArm = (phaseQ != PH_IDLE);
      phaseD        = PH_IDLE;
    end else begin
      unique case (phaseQ)
        PH_IDLE: begin
          if (armReq) begin
            strobe.setArm = 1'b1;
            phaseD        = PH_WAIT;
          end
        end
        PH_WAIT: begin
          if (evTxStart) begin
            phaseD  = PH_ACTIVE;
            cancelD = cancelAfter;
          end else if (cancelAfter) begin
            strobe.clrArm = 1'b1;
            phaseD        = PH_IDLE;
          end
        end
        PH_ACTIVE: begin
          if (evFrameDone) begin
            strobe.clrArm      = 1'b1;
            strobe.setBufEmpty = 1'b1;
            if (armReq) begin
              strobe.setArm = 1'b1;
              phaseD        = PH_WAIT;
            end else begin
              phaseD = PH_IDLE;
            end
          end else if (evTxErr) begin
            strobe.setErr = 1'b1;
            if (cancelAfter) begin
              strobe.clrArm = 1'b1;
              phaseD        = PH_IDLE;
            end else if (shortFrame) begin
              retxD  = 1'b1;
              phaseD = PH_WAIT;
            end else begin
              phaseD = PH_ERRHOLD;
            end
          end else if (evArbLost) begin
            if (cancelAfter) begin
              strobe.clrArm = 1'b1;
              phaseD        = PH_IDLE;
            end else begin
              phaseD = PH_WAIT;
            end
          end else begin
            cancelD = cancelAfter;
          end
        end
        PH_ERRHOLD: begin
          if (armReq) begin
            retxD  = 1'b1;
            phaseD = PH_WAIT;
          end else if (cancelAfter) begin
            strobe.clrArm = 1'b1;
            phaseD        = PH_IDLE;
          end
        end
        default: phaseD = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ  <= PH_IDLE;
      cancelQ <= 1'b0;
      retxQ   <= 1'b0;
    end else begin
      phaseQ  <= phaseD;
      cancelQ <= cancelD;
      retxQ   <= retxD;
    end
  end

  assign retxReq = retxQ;

  // R3: once the frame is on the wire it stays there until an engine event
  a_r3_won_holds: assert property (@(posedge clk) disable iff (!rstN)
    (phaseQ == PH_ACTIVE && !busOff && !evFrameDone && !evTxErr && !evArbLost)
      |=> (phaseQ == PH_ACTIVE));

  // R7: a retransmit pulse always leaves the request waiting for the bus
  a_r7_retx_waits: assert property (@(posedge clk) disable iff (!rstN)
    retxQ |-> (phaseQ == PH_WAIT));

  // R5: bus-off drops the request
  a_r5_busoff_idle: assert property (@(posedge clk) disable iff (!rstN)
    busOff |=> (phaseQ == PH_IDLE && !retxQ));

endmodule

// File: rtl/can_tx_request_dp.sv
module can_tx_request_dp
  import can_tx_request_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  txStrobe_t strobe,
  input  logic      cpuWrCtl,
  input  logic      cpuErrBit,
  input  logic      cpuWrData2,
  input  logic      evShiftLoad2,
  output logic      startFlag,
  output logic      txPending,
  output logic      bufEmpty,
  output logic      txErrFlag
);

  logic errClr;
  assign errClr = cpuWrCtl & ~cpuErrBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startFlag <= 1'b0;
      txPending <= 1'b0;
      bufEmpty  <= 1'b1;
      txErrFlag <= 1'b0;
    end else begin
      // set after clear: a re-arm on completion leaves the flags high
      if (strobe.setArm) begin
        startFlag <= 1'b1;
        txPending <= 1'b1;
      end else if (strobe.clrArm) begin
        startFlag <= 1'b0;
        txPending <= 1'b0;
      end
      if (cpuWrData2) begin
        bufEmpty <= 1'b0;
      end else if (evShiftLoad2 || strobe.setBufEmpty) begin
        bufEmpty <= 1'b1;
      end
      if (strobe.setErr) begin
        txErrFlag <= 1'b1;
      end else if (errClr) begin
        txErrFlag <= 1'b0;
      end
    end
  end

  // R9: shifter load refills the empty flag unless the CPU writes at once
  a_r9_buf_set: assert property (@(posedge clk) disable iff (!rstN)
    (evShiftLoad2 && !cpuWrData2) |=> bufEmpty);

  // R9: a staging write always consumes the empty flag
  a_r9_buf_clr: assert property (@(posedge clk) disable iff (!rstN)
    cpuWrData2 |=> !bufEmpty);

  // R10: an error raised by the control is always visible next cycle
  a_r10_err_set: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setErr |=> txErrFlag);

endmodule

// File: rtl/can_tx_request.sv
module can_tx_request
  import can_tx_request_pkg::*;
#(
  parameter int MAX_DATA_BYTES = 8,
  parameter int AUTO_RETX_MAX  = 2,
  localparam int LEN_W = $clog2(MAX_DATA_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cpuWrCtl,
  input  logic             cpuStartBit,
  input  logic             cpuErrBit,
  input  logic             cpuWrData2,
  input  logic [LEN_W-1:0] dataLen,
  input  logic             evTxStart,
  input  logic             evArbLost,
  input  logic             evTxErr,
  input  logic             evFrameDone,
  input  logic             evShiftLoad2,
  input  logic             busOff,
  output logic             startFlag,
  output logic             txPending,
  output logic             bufEmpty,
  output logic             txErrFlag,
  output logic             retxReq
);

  txStrobe_t strobe;

  can_tx_request_ctl #(
    .MAX_DATA_BYTES(MAX_DATA_BYTES),
    .AUTO_RETX_MAX (AUTO_RETX_MAX)
  ) u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .cpuWrCtl   (cpuWrCtl),
    .cpuStartBit(cpuStartBit),
    .dataLen    (dataLen),
    .evTxStart  (evTxStart),
    .evArbLost  (evArbLost),
    .evTxErr    (evTxErr),
    .evFrameDone(evFrameDone),
    .busOff     (busOff),
    .strobe     (strobe),
    .retxReq    (retxReq)
  );

  can_tx_request_dp u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .cpuWrCtl    (cpuWrCtl),
    .cpuErrBit   (cpuErrBit),
    .cpuWrData2  (cpuWrData2),
    .evShiftLoad2(evShiftLoad2),
    .startFlag   (startFlag),
    .txPending   (txPending),
    .bufEmpty    (bufEmpty),
    .txErrFlag   (txErrFlag)
  );

  // R2: an accepted start write is visible on both flags next cycle
  a_r2_arm: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWrCtl && cpuStartBit && !busOff) |=> (startFlag && txPending));

  // R5: bus-off leaves nothing pending
  a_r5_busoff_flags: assert property (@(posedge clk) disable iff (!rstN)
    busOff |=> (!startFlag && !txPending));

endmodule

// File: tb/can_tx_request_bench.sv
module can_tx_request_bench;

  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cpuWrCtl = 1'b0, cpuStartBit = 1'b0, cpuErrBit = 1'b1, cpuWrData2 = 1'b0;
  logic [3:0] dataLen = 4'd2;
  logic       evTxStart = 1'b0, evArbLost = 1'b0, evTxErr = 1'b0, evFrameDone = 1'b0;
  logic       evShiftLoad2 = 1'b0, busOff = 1'b0;
  logic       startFlag, txPending, bufEmpty, txErrFlag, retxReq;

  int    total = 0;
  int    bad = 0;
  string curReq = "R1";

  always #(CLK_P/2) clk = ~clk;

  can_tx_request u_can_tx_request (
    .clk(clk), .rstN(rstN), .cpuWrCtl(cpuWrCtl), .cpuStartBit(cpuStartBit),
    .cpuErrBit(cpuErrBit), .cpuWrData2(cpuWrData2), .dataLen(dataLen),
    .evTxStart(evTxStart), .evArbLost(evArbLost), .evTxErr(evTxErr),
    .evFrameDone(evFrameDone), .evShiftLoad2(evShiftLoad2), .busOff(busOff),
    .startFlag(startFlag), .txPending(txPending), .bufEmpty(bufEmpty),
    .txErrFlag(txErrFlag), .retxReq(retxReq)
  );

  // behavioural reference: stage 0 none, 1 queued, 2 on wire, 3 awaiting reload
  int mStage;
  bit mWithdraw, mStart, mPend, mEmpty, mErr, mRetx;

  always @(posedge clk) begin
    int nStage;
    bit nWithdraw, arm, wd, drop, raise, fin, errHit, rx;
    if (!rstN) begin
      mStage = 0; mWithdraw = 0; mStart = 0; mPend = 0; mEmpty = 1; mErr = 0; mRetx = 0;
    end else begin
      arm = cpuWrCtl && cpuStartBit && !busOff;
      wd = !arm && (mWithdraw || (cpuWrCtl && !cpuStartBit));
      nStage = mStage; nWithdraw = 0; drop = 0; raise = 0; fin = 0; errHit = 0; rx = 0;
      if (busOff) begin
        drop = 1; nStage = 0;
      end else if (mStage == 0) begin
        if (arm) begin raise = 1; nStage = 1; end
      end else if (mStage == 1) begin
        if (evTxStart) begin nStage = 2; nWithdraw = wd; end
        else if (wd) begin drop = 1; nStage = 0; end
      end else if (mStage == 2) begin
        if (evFrameDone) begin
          drop = 1; fin = 1; nStage = arm ? 1 : 0; raise = arm;
        end else if (evTxErr) begin
          errHit = 1;
          if (wd) begin drop = 1; nStage = 0; end
          else if (dataLen <= 2) begin rx = 1; nStage = 1; end
          else nStage = 3;
        end else if (evArbLost) begin
          if (wd) begin drop = 1; nStage = 0; end else nStage = 1;
        end else nWithdraw = wd;
      end else begin
        if (arm) begin rx = 1; nStage = 1; end
        else if (wd) begin drop = 1; nStage = 0; end
      end
      if (raise) begin mStart = 1; mPend = 1; end
      else if (drop) begin mStart = 0; mPend = 0; end
      if (cpuWrData2) mEmpty = 0;
      else if (fin || evShiftLoad2) mEmpty = 1;
      if (errHit) mErr = 1;
      else if (cpuWrCtl && !cpuErrBit) mErr = 0;
      mRetx = rx; mStage = nStage; mWithdraw = nWithdraw;
    end
  end

  task automatic chk(string req, string nm, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, nm, act, exp, $time);
    end
  endtask

  task automatic cmpModel();
    chk(curReq, "startFlag", startFlag, mStart);
    chk(curReq, "txPending", txPending, mPend);
    chk(curReq, "bufEmpty", bufEmpty, mEmpty);
    chk(curReq, "txErrFlag", txErrFlag, mErr);
    chk(curReq, "retxReq", retxReq, mRetx);
  endtask

  // advance one edge, compare at the following falling edge, drop strobes
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    cmpModel();
    cpuWrCtl = 0; cpuStartBit = 0; cpuErrBit = 1; cpuWrData2 = 0;
    evTxStart = 0; evArbLost = 0; evTxErr = 0; evFrameDone = 0; evShiftLoad2 = 0;
  endtask

  task automatic wrCtl(bit s, bit e);
    cpuWrCtl = 1; cpuStartBit = s; cpuErrBit = e;
  endtask

  task automatic flags(string req, bit exp);
    chk(req, "startFlag", startFlag, exp);
    chk(req, "txPending", txPending, exp);
  endtask

  initial begin
    #(CLK_P * 100000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "startFlag", startFlag, 0);
    chk("R1", "bufEmpty", bufEmpty, 1);
    rstN = 1;
    tick();
    chk("R1", "txErrFlag", txErrFlag, 0);
    chk("R1", "retxReq", retxReq, 0);

    curReq = "R2";
    wrCtl(1, 1); tick(); flags("R2", 1);
    repeat (4) tick();
    flags("R2", 1);

    curReq = "R3";
    wrCtl(0, 1); tick(); flags("R3", 0);
    wrCtl(1, 1); tick();
    evTxStart = 1; tick();
    wrCtl(0, 1); tick(); flags("R3", 1);
    repeat (3) tick();
    flags("R3", 1);
    evFrameDone = 1; tick(); flags("R3", 0);

    curReq = "R4";
    wrCtl(1, 1); tick(); evTxStart = 1; tick();
    wrCtl(0, 1); tick();
    evArbLost = 1; tick(); flags("R4", 0);
    wrCtl(1, 1); tick(); evTxStart = 1; tick();
    evArbLost = 1; tick(); flags("R4", 1);
    evTxStart = 1; tick(); evFrameDone = 1; tick();

    curReq = "R5";
    wrCtl(1, 1); tick();
    busOff = 1; tick(); flags("R5", 0);
    wrCtl(1, 1); tick(); flags("R5", 0);
    busOff = 0; tick(); flags("R5", 0);

    curReq = "R6";
    cpuWrData2 = 1; tick();
    wrCtl(1, 1); tick(); evTxStart = 1; tick();
    evFrameDone = 1; wrCtl(1, 1); tick();
    flags("R6", 1);
    chk("R6", "bufEmpty", bufEmpty, 1);
    evTxStart = 1; tick(); evFrameDone = 1; tick(); flags("R6", 0);

    curReq = "R7";
    dataLen = 4'd2;
    wrCtl(1, 1); tick(); evTxStart = 1; tick();
    evTxErr = 1; tick();
    chk("R7", "retxReq", retxReq, 1); flags("R7", 1);
    tick(); chk("R7", "retxReq", retxReq, 0);
    evTxStart = 1; tick(); wrCtl(0, 1); tick();
    evTxErr = 1; tick();
    chk("R7", "retxReq", retxReq, 0); flags("R7", 0);

    curReq = "R8";
    dataLen = 4'd5;
    wrCtl(1, 1); tick(); evTxStart = 1; tick();
    evTxErr = 1; tick();
    chk("R8", "retxReq", retxReq, 0); flags("R8", 1);
    repeat (2) tick();
    wrCtl(1, 1); tick(); chk("R8", "retxReq", retxReq, 1);
    evTxStart = 1; tick(); evTxErr = 1; tick();
    wrCtl(0, 1); tick(); flags("R8", 0);

    curReq = "R9";
    cpuWrData2 = 1; tick(); chk("R9", "bufEmpty", bufEmpty, 0);
    evShiftLoad2 = 1; tick(); chk("R9", "bufEmpty", bufEmpty, 1);
    evShiftLoad2 = 1; cpuWrData2 = 1; tick(); chk("R9", "bufEmpty", bufEmpty, 0);

    curReq = "R10";
    chk("R10", "txErrFlag", txErrFlag, 1);
    wrCtl(0, 1); tick(); chk("R10", "txErrFlag", txErrFlag, 1);
    wrCtl(0, 0); tick(); chk("R10", "txErrFlag", txErrFlag, 0);
    repeat (2) tick();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule